// File: doc/BRIEF.md
# Set/Reset State Register Bank with Output Cells

The block holds a row of set/reset state bits, each fed by its own set line and clear line from surrounding logic. On every active clock edge each bit keeps, sets or clears its value according to its two lines. A single configuration input picks the active edge: rising or falling. The register contents always come back out on a feedback bus, so surrounding logic can use them as state.

Each bit has an output cell. The cell can send the stored value to the bit's output. It can also send the bit's set line straight through, so that the output follows that line in the same cycle.

One shared pin has two roles. In the plain mode it is only a logic level that is passed on, and every output stays enabled. In the enable mode it is still passed on, but it also acts as an active-low enable for all outputs together. When the pin is high, every per-bit enable drops, and the pad outside the block puts that output in high impedance.

Top module: `srq_bank`

## Requirements
- R1: While `rst` is high at an active edge, every stored bit becomes 0, so `state_o` reads all zeros after that edge.
- R2: With set=0 and clear=0 at an active edge, a bit keeps its previous value.
- R3: With set=1 and clear=0 at an active edge, the bit becomes 1.
- R4: With set=0 and clear=1 at an active edge, the bit becomes 0.
- R5: Set=1 with clear=1 is an illegal pattern. The next value of that bit is unspecified (X in simulation). The other bits follow their own lines, and a later clear alone brings the bit back to 0.
- R6: `comb_sel_i[k]`=0 selects registered mode, where `q_o[k]` shows the stored bit. `comb_sel_i[k]`=1 selects combinational mode, where `q_o[k]` equals `set_i[k]` in the same cycle, with no clock delay.
- R7: `state_o` shows the stored bits whatever each bit's output mode is.
- R8: `clk_fall_i`=0 makes the rising edge of `clk` active, and `clk_fall_i`=1 makes the falling edge active. No bit changes on the other edge. The polarity is only changed while `rst` is high.
- R9: With `oe_mode_i`=0, every bit of `q_en_o` is 1 whatever the level of `oe_pin_i`.
- R10: With `oe_mode_i`=1, `oe_pin_i`=0 sets every bit of `q_en_o` to 1 and `oe_pin_i`=1 sets every bit to 0.
- R11: `pin_level_o` equals `oe_pin_i` in both enable modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, sampled on the active edge |
| clk_fall_i | input | 1 | 0: rising edge active, 1: falling edge active |
| oe_mode_i | input | 1 | 0: shared pin is a plain input, 1: shared pin is also an active-low enable |
| oe_pin_i | input | 1 | Shared pin level |
| set_i | input | W (8) | Per-bit set lines |
| clr_i | input | W (8) | Per-bit clear lines |
| comb_sel_i | input | W (8) | Per-bit output mode, 1 = combinational |
| q_o | output | W (8) | Per-bit output values |
| q_en_o | output | W (8) | Per-bit output enables, 1 = driven |
| state_o | output | W (8) | Stored bits, for feedback |
| pin_level_o | output | 1 | Shared pin level passed on as a logic input |

## Verification
The set/clear lines are driven with mixed bit patterns in which set-only, clear-only, idle and conflicting bits occur in the same cycle. This separates the four per-bit actions and shows that the bits are independent. Combinational mode is checked before the active edge, while the stored value still differs from the set line, so a registered path cannot pass for a direct one. In falling-edge mode the state is sampled just after the rising edge and again just after the falling edge, which tells the two edges apart. The enable is tried with all four mode and pin combinations.

// File: rtl/srq_pkg.sv
package srq_pkg;

  // Per-bit action decoded from {set, clear}
  typedef enum logic [1:0] {
    OP_KEEP = 2'b00,
    OP_ZERO = 2'b01,
    OP_ONE  = 2'b10,
    OP_BAD  = 2'b11
  } sr_op_e;

  function automatic sr_op_e sr_decode(input logic s, input logic r);
    return sr_op_e'({s, r});
  endfunction

endpackage

// File: rtl/srq_edge_sel.sv
module srq_edge_sel (
  input  logic clk,
  input  logic fall_i,
  output logic act_clk_o
);
  // Inverting the clock makes the falling edge the rising edge of act_clk_o
  assign act_clk_o = clk ^ fall_i;
endmodule

// File: rtl/srq_store.sv
module srq_store #(
  parameter int W = 8
) (
  input  logic         act_clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] state_o
);
  import srq_pkg::*;

  for (genvar k = 0; k < W; k++) begin : g_bit
    logic bit_q;

    always_ff @(posedge act_clk) begin
      if (rst) begin
        bit_q <= 1'b0;
      end else begin
        unique case (sr_decode(set_i[k], clr_i[k]))
          OP_KEEP: bit_q <= bit_q;
          OP_ZERO: bit_q <= 1'b0;
          OP_ONE:  bit_q <= 1'b1;
          default: bit_q <= 1'bx;
        endcase
      end
    end

    assign state_o[k] = bit_q;

    AST_IDLE_KEEPS: assert property (@(posedge act_clk) disable iff (rst)
      (!set_i[k] && !clr_i[k]) |=> (state_o[k] == $past(state_o[k]))); // R2
    AST_SET_ONLY: assert property (@(posedge act_clk) disable iff (rst)
      (set_i[k] && !clr_i[k]) |=> state_o[k]); // R3
    AST_CLR_ONLY: assert property (@(posedge act_clk) disable iff (rst)
      (!set_i[k] && clr_i[k]) |=> !state_o[k]); // R4
    AST_RESET_ZERO: assert property (@(posedge act_clk)
      rst |=> !state_o[k]); // R1
  end

endmodule

// File: rtl/srq_out_cell.sv
module srq_out_cell #(
  parameter int W = 8
) (
  input  logic         act_clk,
  input  logic         rst,
  input  logic [W-1:0] comb_sel_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] state_i,
  output logic [W-1:0] q_o
);

  for (genvar k = 0; k < W; k++) begin : g_cell
    assign q_o[k] = comb_sel_i[k] ? set_i[k] : state_i[k];

    // A registered output shows a set only after the active edge
    AST_REG_PATH: assert property (@(posedge act_clk) disable iff (rst)
      (set_i[k] && !clr_i[k]) |=> (comb_sel_i[k] || q_o[k])); // R6
  end

endmodule

// File: rtl/srq_oe_ctrl.sv
module srq_oe_ctrl #(
  parameter int W = 8
) (
  input  logic         oe_mode_i,
  input  logic         oe_pin_i,
  output logic [W-1:0] en_o,
  output logic         pin_level_o
);
  logic drive_all;

  always_comb begin
    drive_all   = !(oe_mode_i && oe_pin_i);
    en_o        = {W{drive_all}};
    pin_level_o = oe_pin_i;
  end

endmodule

// File: rtl/srq_bank.sv
module srq_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clk_fall_i,
  input  logic         oe_mode_i,
  input  logic         oe_pin_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] comb_sel_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_en_o,
  output logic [W-1:0] state_o,
  output logic         pin_level_o
);

  logic act_clk;

  srq_edge_sel u_edge (
    .clk       (clk),
    .fall_i    (clk_fall_i),
    .act_clk_o (act_clk)
  );

  srq_store #(.W(W)) u_store (
    .act_clk (act_clk),
    .rst     (rst),
    .set_i   (set_i),
    .clr_i   (clr_i),
    .state_o (state_o)
  );

  srq_out_cell #(.W(W)) u_cell (
    .act_clk    (act_clk),
    .rst        (rst),
    .comb_sel_i (comb_sel_i),
    .set_i      (set_i),
    .clr_i      (clr_i),
    .state_i    (state_o),
    .q_o        (q_o)
  );

  srq_oe_ctrl #(.W(W)) u_oe (
    .oe_mode_i   (oe_mode_i),
    .oe_pin_i    (oe_pin_i),
    .en_o        (q_en_o),
    .pin_level_o (pin_level_o)
  );

  AST_PLAIN_ALL_ON: assert property (@(posedge act_clk) disable iff (rst)
    !oe_mode_i |-> (q_en_o == {W{1'b1}})); // R9
  AST_PIN_HIGH_OFF: assert property (@(posedge act_clk) disable iff (rst)
    (oe_mode_i && oe_pin_i) |-> (q_en_o == {W{1'b0}})); // R10

endmodule

// File: tb/srq_bank_tb_top.sv
module srq_bank_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clk_fall_i = 1'b0;
  logic         oe_mode_i = 1'b0;
  logic         oe_pin_i = 1'b0;
  logic [W-1:0] set_i = '0;
  logic [W-1:0] clr_i = '0;
  logic [W-1:0] comb_sel_i = '0;
  logic [W-1:0] q_o, q_en_o, state_o;
  logic         pin_level_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [W-1:0] m_st = '0;
  logic [W-1:0] m_known = '0;

  typedef struct {
    logic [W-1:0] q, mq, st, mst, en;
    logic         lvl;
    string        tag;
  } exp_t;

  exp_t sb[$];
  event mon_ev;

  always #4 clk = ~clk;

  srq_bank #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .clk_fall_i(clk_fall_i), .oe_mode_i(oe_mode_i),
    .oe_pin_i(oe_pin_i), .set_i(set_i), .clr_i(clr_i), .comb_sel_i(comb_sel_i),
    .q_o(q_o), .q_en_o(q_en_o), .state_o(state_o), .pin_level_o(pin_level_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_active();
    if (clk_fall_i) @(negedge clk);
    else @(posedge clk);
  endtask

  // Driver: apply lines, let one active edge pass, predict and queue
  task automatic cycle(input logic [W-1:0] s, input logic [W-1:0] c, input string tag);
    exp_t it;
    set_i = s;
    clr_i = c;
    wait_active();
    for (int k = 0; k < W; k++) begin
      if (rst) begin m_st[k] = 1'b0; m_known[k] = 1'b1; end
      else if (s[k] && !c[k]) begin m_st[k] = 1'b1; m_known[k] = 1'b1; end
      else if (!s[k] && c[k]) begin m_st[k] = 1'b0; m_known[k] = 1'b1; end
      else if (s[k] && c[k]) begin m_known[k] = 1'b0; end
    end
    #1;
    for (int k = 0; k < W; k++) begin
      it.q[k]  = comb_sel_i[k] ? s[k] : m_st[k];
      it.mq[k] = comb_sel_i[k] ? 1'b1 : m_known[k];
    end
    it.st  = m_st;
    it.mst = m_known;
    it.en  = (oe_mode_i && oe_pin_i) ? '0 : '1;
    it.lvl = oe_pin_i;
    it.tag = tag;
    sb.push_back(it);
    ->mon_ev;
    #1;
  endtask

  // Monitor: pop predictions and compare with the ports
  initial begin
    exp_t e;
    forever begin
      @(mon_ev);
      while (sb.size() > 0) begin
        e = sb.pop_front();
        chk(((state_o ^ e.st) & e.mst) == '0, {e.tag, " state"}, 32'(state_o), 32'(e.st));
        chk(((q_o ^ e.q) & e.mq) == '0, {e.tag, " q"}, 32'(q_o), 32'(e.q));
        chk(q_en_o == e.en, {e.tag, " en"}, 32'(q_en_o), 32'(e.en));
        chk(pin_level_o == e.lvl, {e.tag, " R11 level"}, 32'(pin_level_o), 32'(e.lvl));
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2;
    // R1: reset state
    cycle('0, '0, "R1 reset");
    cycle(8'hFF, '0, "R1 reset beats set");
    rst = 1'b0;
    // R3, R2, R4 with mixed patterns
    cycle(8'hA5, 8'h00, "R3 set pattern");
    cycle(8'h00, 8'h00, "R2 hold");
    cycle(8'h00, 8'h0F, "R4 clear low nibble");
    cycle(8'h0F, 8'hF0, "R3 R4 swap nibbles");
    cycle(8'h00, 8'h00, "R2 hold again");
    cycle(8'h40, 8'h01, "R2 R3 R4 mixed");
    // R5: conflict on bit 4, other bits independent
    cycle(8'h11, 8'h10, "R5 conflict neighbours");
    cycle(8'h00, 8'h10, "R5 recover by clear");
    // R6 combinational mode seen before the edge, R7 feedback
    comb_sel_i = 8'hF0;
    set_i = 8'hC0;
    clr_i = 8'h00;
    #1;
    chk(q_o[7:4] == 4'hC, "R6 comb follows set before edge", 32'(q_o[7:4]), 32'hC);
    chk(state_o[7:4] == m_st[7:4], "R7 state unchanged before edge", 32'(state_o), 32'(m_st));
    chk(q_o[3:0] == m_st[3:0], "R6 registered bits unchanged", 32'(q_o[3:0]), 32'(m_st[3:0]));
    cycle(8'hC0, 8'h00, "R6 R7 comb mode edge");
    cycle(8'h00, 8'hFF, "R6 R7 comb mode clear");
    cycle(8'h5A, 8'h00, "R6 R7 comb mode set");
    comb_sel_i = 8'h00;
    // R9 / R10 output enable
    oe_mode_i = 1'b0; oe_pin_i = 1'b1;
    cycle(8'h00, 8'h00, "R9 plain mode pin high");
    oe_mode_i = 1'b1; oe_pin_i = 1'b0;
    cycle(8'h00, 8'h00, "R10 enable mode pin low");
    oe_pin_i = 1'b1;
    cycle(8'h81, 8'h00, "R10 enable mode pin high");
    oe_mode_i = 1'b0; oe_pin_i = 1'b0;
    cycle(8'h00, 8'h00, "R9 plain mode pin low");
    // R8 falling-edge mode, switched under reset
    rst = 1'b1;
    clk_fall_i = 1'b1;
    cycle('0, '0, "R8 R1 reset in falling mode");
    rst = 1'b0;
    set_i = 8'h3C;
    clr_i = 8'h00;
    @(posedge clk);
    #1;
    chk(state_o == 8'h00, "R8 no update on rising edge", 32'(state_o), 32'h0);
    @(negedge clk);
    #1;
    chk(state_o == 8'h3C, "R8 update on falling edge", 32'(state_o), 32'h3C);
    m_st = 8'h3C;
    m_known = '1;
    #1;
    cycle(8'h00, 8'h0C, "R8 R4 falling mode clear");
    cycle(8'h00, 8'h00, "R8 R2 falling mode hold");
    #3;
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule